// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the command front end of a parallel NOR flash model. It watches bus write cycles and recognises the multi-cycle command sequences that start a word program, a block erase or a chip erase. It also handles suspending and resuming a block erase, and entering and leaving a shortcut mode that skips the two unlock cycles. A write counts when `ce_i` and `we_i` are both high at a rising clock edge. Command codes are taken from the low data byte. Sequence keys are matched on the low address bits only.

When a sequence completes, the block raises `start_o` for one cycle. On that cycle `op_o`, `op_addr_o` and `op_data_o` hold the operation code and the address and data of the write that completed the sequence. These outputs go to an array engine. The engine reports the end of the work on `done_i`. `ready_o` is low while an operation runs, and also during the fixed stall that follows a command aimed at a block the surrounding protection logic marks as locked through `lock_i`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `ready_o` is 1 and `start_o` is 0.
- R2: The four writes AAh at key 555h, 55h at key 2AAh, A0h at key 555h, and then any address and data give a single-cycle `start_o` in the cycle after the last write. On that pulse `op_o`=1, and the address and data of the last write appear on the op outputs. `ready_o` goes low in that same cycle.
- R3: The 555h and 2AAh keys compare only address bits [11:0], and command codes compare only data bits [7:0]. Upper address and data bits have no effect on decoding.
- R4: Outside the shortcut mode, a write that does not match the next expected step ends the sequence and returns to read mode. F0h is one such write. A later complete sequence still starts normally.
- R5: Block erase is AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at the block address, and gives `op_o`=2. The same prefix followed by 10h@555h gives chip erase with `op_o`=3.
- R6: `ready_o` stays low until `done_i`. While busy, no write starts an operation except an accepted suspend.
- R7: B0h at any address during a block erase gives a pulse with `op_o`=4, and `ready_o` goes high. B0h during a program or a chip erase has no effect. If `done_i` and a B0h write fall in the same cycle, the completion wins and no suspend pulse is produced.
- R8: In the suspended state, 30h at any address gives a pulse with `op_o`=5 and `ready_o` goes low. Other writes start nothing.
- R9: AAh@555h, 55h@2AAh, 20h@555h enters the shortcut mode. In that mode A0h followed by address and data starts a program, and 80h followed by 30h or 10h starts a block or chip erase. Addresses are don't-care except in the final write. After `done_i` the decoder is back in the shortcut mode.
- R10: In the shortcut mode, 90h followed by 00h returns to read mode. After that, A0h plus a word starts nothing.
- R11: If `lock_i` is high on the final write of a program or block erase, no start is given and `ready_o` is low for exactly PROT_PROG_CYC or PROT_ERASE_CYC cycles respectively. Chip erase does not depend on `lock_i`.
- R12: In the shortcut mode, a write that does not match the next step stays in the shortcut mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable, qualifies a write |
| we_i | input | 1 | Write enable, qualifies a write |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data |
| lock_i | input | 1 | Target of the current write is protected |
| done_i | input | 1 | Array engine finished the running operation |
| ready_o | output | 1 | High when no operation or protection stall is active |
| start_o | output | 1 | One-cycle operation start |
| op_o | output | 3 | Operation code: 1 program, 2 block erase, 3 chip erase, 4 suspend, 5 resume |
| op_addr_o | output | ADDR_W | Address captured with the last start |
| op_data_o | output | DATA_W | Data captured with the last start |

## Verification
Two events can land on the same edge: the array engine reporting completion on `done_i`, and a B0h suspend write for a block erase that is still running. The bench starts a block erase and then drives `done_i` and the B0h write in one cycle. It expects no suspend pulse in the scoreboard, with `ready_o` high and the decoder back in read mode. The bench also places B0h writes inside programs and chip erases, and places command writes inside busy windows and suspended windows. In each case the scoreboard must see exactly the pulses the requirements predict.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    S_READ,
    S_UNL1,
    S_UNL2,
    S_PRG,
    S_E1,
    S_E2,
    S_E3,
    S_BYP,
    S_BYP_PRG,
    S_BYP_ERS,
    S_BYP_EXIT,
    S_BUSY,
    S_SUSP,
    S_LOCK
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PROG    = 3'd1,
    OP_BERASE  = 3'd2,
    OP_CERASE  = 3'd3,
    OP_SUSPEND = 3'd4,
    OP_RESUME  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    J_PROG,
    J_BERASE,
    J_CERASE
  } job_e;

  localparam logic [7:0]  CMD_KEY_A    = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B    = 8'h55;
  localparam logic [7:0]  CMD_PROG     = 8'hA0;
  localparam logic [7:0]  CMD_ERS_SET  = 8'h80;
  localparam logic [7:0]  CMD_CHIP     = 8'h10;
  localparam logic [7:0]  CMD_BLOCK    = 8'h30;
  localparam logic [7:0]  CMD_SUSP     = 8'hB0;
  localparam logic [7:0]  CMD_RESUME   = 8'h30;
  localparam logic [7:0]  CMD_BYP_IN   = 8'h20;
  localparam logic [7:0]  CMD_BYP_OUT1 = 8'h90;
  localparam logic [7:0]  CMD_BYP_OUT2 = 8'h00;

  localparam logic [11:0] KEY_ADDR_A   = 12'h555;
  localparam logic [11:0] KEY_ADDR_B   = 12'h2AA;

  function automatic op_e job_to_op(input job_e j);
    case (j)
      J_PROG:   job_to_op = OP_PROG;
      J_BERASE: job_to_op = OP_BERASE;
      default:  job_to_op = OP_CERASE;
    endcase
  endfunction

endpackage

// File: rtl/fcd_rst_sync.sv
module fcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fcd_bus_decode.sv
module fcd_bus_decode import fcd_pkg::*; #(
  parameter int MATCH_W = 12
) (
  input  logic               ce_i,
  input  logic               we_i,
  input  logic [MATCH_W-1:0] addr_key_i,
  output logic               wr_o,
  output logic               key_a_o,
  output logic               key_b_o
);
  localparam logic [MATCH_W-1:0] KA = MATCH_W'(KEY_ADDR_A);
  localparam logic [MATCH_W-1:0] KB = MATCH_W'(KEY_ADDR_B);

  assign wr_o    = ce_i & we_i;
  assign key_a_o = (addr_key_i == KA);
  assign key_b_o = (addr_key_i == KB);
endmodule

// File: rtl/fcd_guard_timer.sv
module fcd_guard_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm import fcd_pkg::*; #(
  parameter int ADDR_W         = 21,
  parameter int DATA_W         = 16,
  parameter int CNT_W          = 13,
  parameter int PROT_PROG_CYC  = 100,
  parameter int PROT_ERASE_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              key_a_i,
  input  logic              key_b_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              lock_i,
  input  logic              done_i,
  input  logic              tmr_expire_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              start_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              ready_o
);
  seq_state_e        st_q, st_d;
  logic              byp_q, byp_d;
  job_e              job_q, job_d;
  logic              start_q, start_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic [7:0] code;
  logic       step_a, step_b, launch;
  job_e       launch_job;
  seq_state_e home;

  assign code   = data_i[7:0];
  assign step_a = wr_i & key_a_i & (code == CMD_KEY_A);
  assign step_b = wr_i & key_b_i & (code == CMD_KEY_B);
  assign home   = byp_q ? S_BYP : S_READ;

  always_comb begin
    st_d       = st_q;
    byp_d      = byp_q;
    job_d      = job_q;
    start_d    = 1'b0;
    op_d       = op_q;
    launch     = 1'b0;
    launch_job = J_PROG;
    tmr_load_o = 1'b0;
    tmr_val_o  = CNT_W'(PROT_PROG_CYC);

    case (st_q)
      S_READ: if (step_a) st_d = S_UNL1;
      S_UNL1: if (wr_i) st_d = step_b ? S_UNL2 : S_READ;
      S_UNL2: begin
        if (wr_i) begin
          st_d = S_READ;
          if (key_a_i) begin
            if (code == CMD_PROG)         st_d = S_PRG;
            else if (code == CMD_ERS_SET) st_d = S_E1;
            else if (code == CMD_BYP_IN) begin
              st_d  = S_BYP;
              byp_d = 1'b1;
            end
          end
        end
      end
      S_PRG: if (wr_i) begin
        launch     = 1'b1;
        launch_job = J_PROG;
      end
      S_E1: if (wr_i) st_d = step_a ? S_E2 : S_READ;
      S_E2: if (wr_i) st_d = step_b ? S_E3 : S_READ;
      S_E3: begin
        if (wr_i) begin
          st_d = S_READ;
          if (code == CMD_BLOCK) begin
            launch     = 1'b1;
            launch_job = J_BERASE;
          end else if (code == CMD_CHIP && key_a_i) begin
            launch     = 1'b1;
            launch_job = J_CERASE;
          end
        end
      end
      S_BYP: begin
        if (wr_i) begin
          if (code == CMD_PROG)          st_d = S_BYP_PRG;
          else if (code == CMD_ERS_SET)  st_d = S_BYP_ERS;
          else if (code == CMD_BYP_OUT1) st_d = S_BYP_EXIT;
        end
      end
      S_BYP_PRG: if (wr_i) begin
        launch     = 1'b1;
        launch_job = J_PROG;
      end
      S_BYP_ERS: begin
        if (wr_i) begin
          st_d = S_BYP;
          if (code == CMD_BLOCK) begin
            launch     = 1'b1;
            launch_job = J_BERASE;
          end else if (code == CMD_CHIP) begin
            launch     = 1'b1;
            launch_job = J_CERASE;
          end
        end
      end
      S_BYP_EXIT: begin
        if (wr_i) begin
          if (code == CMD_BYP_OUT2) begin
            st_d  = S_READ;
            byp_d = 1'b0;
          end else begin
            st_d = S_BYP;
          end
        end
      end
      S_BUSY: begin
        if (done_i) begin
          st_d = home;
        end else if (wr_i && code == CMD_SUSP && job_q == J_BERASE) begin
          st_d    = S_SUSP;
          start_d = 1'b1;
          op_d    = OP_SUSPEND;
        end
      end
      S_SUSP: begin
        if (wr_i && code == CMD_RESUME) begin
          st_d    = S_BUSY;
          start_d = 1'b1;
          op_d    = OP_RESUME;
        end
      end
      S_LOCK: if (tmr_expire_i) st_d = home;
      default: st_d = S_READ;
    endcase

    if (launch) begin
      job_d = launch_job;
      if (lock_i && launch_job != J_CERASE) begin
        st_d       = S_LOCK;
        tmr_load_o = 1'b1;
        tmr_val_o  = (launch_job == J_PROG) ? CNT_W'(PROT_PROG_CYC)
                                            : CNT_W'(PROT_ERASE_CYC);
      end else begin
        st_d    = S_BUSY;
        start_d = 1'b1;
        op_d    = job_to_op(launch_job);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_READ;
      byp_q   <= 1'b0;
      job_q   <= J_PROG;
      start_q <= 1'b0;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      byp_q   <= byp_d;
      job_q   <= job_d;
      start_q <= start_d;
      if (start_d) begin
        op_q   <= op_d;
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign start_o   = start_q;
  assign op_o      = op_q;
  assign op_addr_o = addr_q;
  assign op_data_o = data_q;
  assign ready_o   = !(st_q == S_BUSY || st_q == S_LOCK);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder import fcd_pkg::*; #(
  parameter int ADDR_W         = 21,
  parameter int DATA_W         = 16,
  parameter int MATCH_W        = 12,
  parameter int PROT_PROG_CYC  = 100,
  parameter int PROT_ERASE_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              lock_i,
  input  logic              done_i,
  output logic              ready_o,
  output logic              start_o,
  output logic [2:0]        op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o
);
  localparam int MAX_CYC = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             rst_core_n;
  logic             wr, key_a, key_b;
  logic             tmr_load, tmr_expire;
  logic [CNT_W-1:0] tmr_val;
  op_e              op_int;

  fcd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  fcd_bus_decode #(.MATCH_W(MATCH_W)) u_dec (
    .ce_i       (ce_i),
    .we_i       (we_i),
    .addr_key_i (addr_i[MATCH_W-1:0]),
    .wr_o       (wr),
    .key_a_o    (key_a),
    .key_b_o    (key_b)
  );

  fcd_guard_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (tmr_expire)
  );

  fcd_seq_fsm #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .CNT_W          (CNT_W),
    .PROT_PROG_CYC  (PROT_PROG_CYC),
    .PROT_ERASE_CYC (PROT_ERASE_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .wr_i         (wr),
    .key_a_i      (key_a),
    .key_b_i      (key_b),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .lock_i       (lock_i),
    .done_i       (done_i),
    .tmr_expire_i (tmr_expire),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .start_o      (start_o),
    .op_o         (op_int),
    .op_addr_o    (op_addr_o),
    .op_data_o    (op_data_o),
    .ready_o      (ready_o)
  );

  assign op_o = op_int;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_i,
  input logic       we_i,
  input logic       ready_o,
  input logic       start_o,
  input logic [2:0] op_o
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R2

  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(ce_i && we_i)); // R2

  AST_START_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (op_o != 3'd0 && op_o <= 3'd5)); // R2

  AST_BUSY_ONLY_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ready_o) && start_o) |-> op_o == 3'd4); // R6

  AST_SUSPEND_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && op_o == 3'd4) |-> ready_o); // R7

  AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && op_o == 3'd5) |-> !ready_o); // R8

  AST_RUN_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && op_o != 3'd4) |-> !ready_o); // R2
endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_i    (ce_i),
  .we_i    (we_i),
  .ready_o (ready_o),
  .start_o (start_o),
  .op_o    (op_o)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int PPC = 100;
  localparam int PEC = 5000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_i = 1'b0, we_i = 1'b0, lock_i = 1'b0, done_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic          ready_o, start_o;
  logic [2:0]    op_o;
  logic [AW-1:0] op_addr_o;
  logic [DW-1:0] op_data_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  flash_cmd_decoder #(
    .ADDR_W(AW), .DATA_W(DW), .MATCH_W(12),
    .PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .we_i(we_i),
    .addr_i(addr_i), .data_i(data_i), .lock_i(lock_i), .done_i(done_i),
    .ready_o(ready_o), .start_o(start_o), .op_o(op_o),
    .op_addr_o(op_addr_o), .op_data_o(op_data_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_start(input logic [2:0] op, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.op = op; e.addr = a; e.data = d; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ce_i = 1'b1; we_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    ce_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(21'h555, 16'h00AA);
    bus_wr(21'h2AA, 16'h0055);
  endtask

  task automatic erase_prefix();
    unlock();
    bus_wr(21'h555, 16'h0080);
    unlock();
  endtask

  task automatic sb_drained(input string tag);
    chk(tag, sb_q.size(), 0);
  endtask

  // Scoreboard monitor: every start pulse is matched against the queue
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && start_o) begin
      if (sb_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R6 unexpected start act=%0d exp=none", op_o);
      end else begin
        e = sb_q.pop_front();
        chk(e.tag, {op_o, op_addr_o, op_data_o}, {e.op, e.addr, e.data});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ready", ready_o, 1);
    chk("R1 start", start_o, 0);

    // R2 program, with R7 suspend ignored and R6 commands ignored while busy
    expect_start(3'd1, 21'h12345, 16'hBEEF, "R2 program");
    unlock();
    bus_wr(21'h555, 16'h00A0);
    bus_wr(21'h12345, 16'hBEEF);
    chk("R2 ready low", ready_o, 0);
    bus_wr(21'h555, 16'h00B0);
    chk("R7 suspend ignored in program", ready_o, 0);
    unlock();
    bus_wr(21'h555, 16'h00A0);
    bus_wr(21'h00400, 16'h1111);
    chk("R6 still busy", ready_o, 0);
    finish_op();
    chk("R6 ready after done", ready_o, 1);
    sb_drained("R2 drained");

    // R3 upper address and data bits ignored
    expect_start(3'd1, 21'h00010, 16'h0F0F, "R3 program");
    bus_wr(21'h1F555, 16'h12AA);
    bus_wr(21'h0A2AA, 16'hFF55);
    bus_wr(21'h07555, 16'hFFA0);
    bus_wr(21'h00010, 16'h0F0F);
    finish_op();
    sb_drained("R3 drained");

    // R4 bad cycles abort
    bus_wr(21'h555, 16'h00AA);
    bus_wr(21'h2AB, 16'h0055);
    bus_wr(21'h555, 16'h00A0);
    bus_wr(21'h00100, 16'h0001);
    chk("R4 bad key ready", ready_o, 1);
    bus_wr(21'h555, 16'h00AA);
    bus_wr(21'h2AA, 16'h00F0);
    bus_wr(21'h555, 16'h00A0);
    bus_wr(21'h00200, 16'h1234);
    chk("R4 reset code ready", ready_o, 1);
    expect_start(3'd1, 21'h00300, 16'h00C3, "R4 recovery");
    unlock();
    bus_wr(21'h555, 16'h00A0);
    bus_wr(21'h00300, 16'h00C3);
    finish_op();
    sb_drained("R4 drained");

    // R5 block erase, R7 suspend, R8 resume
    expect_start(3'd2, 21'h0C000, 16'h0030, "R5 block erase");
    erase_prefix();
    bus_wr(21'h0C000, 16'h0030);
    chk("R5 busy", ready_o, 0);
    expect_start(3'd4, 21'h00007, 16'h00B0, "R7 suspend");
    bus_wr(21'h00007, 16'h00B0);
    chk("R7 ready in suspend", ready_o, 1);
    bus_wr(21'h555, 16'h00A0);
    chk("R8 write in suspend no start", ready_o, 1);
    expect_start(3'd5, 21'h00009, 16'h0030, "R8 resume");
    bus_wr(21'h00009, 16'h0030);
    chk("R8 busy after resume", ready_o, 0);
    finish_op();
    chk("R8 ready after done", ready_o, 1);
    sb_drained("R8 drained");

    // R5 chip erase, R7 suspend ignored
    expect_start(3'd3, 21'h10555, 16'h0010, "R5 chip erase");
    erase_prefix();
    bus_wr(21'h10555, 16'h0010);
    bus_wr(21'h555, 16'h00B0);
    chk("R7 suspend ignored in chip erase", ready_o, 0);
    finish_op();
    sb_drained("R5 drained");

    // R7 done and suspend in the same cycle: completion wins
    expect_start(3'd2, 21'h04000, 16'h0030, "R7 erase before clash");
    erase_prefix();
    bus_wr(21'h04000, 16'h0030);
    @(negedge clk);
    ce_i = 1'b1; we_i = 1'b1; addr_i = 21'h555; data_i = 16'h00B0; done_i = 1'b1;
    @(negedge clk);
    ce_i = 1'b0; we_i = 1'b0; done_i = 1'b0;
    chk("R7 clash ready", ready_o, 1);
    repeat (2) @(negedge clk);
    sb_drained("R7 clash drained");

    // R9 bypass mode
    unlock();
    bus_wr(21'h555, 16'h0020);
    chk("R9 entry no busy", ready_o, 1);
    expect_start(3'd1, 21'h00333, 16'h5555, "R9 bypass program");
    bus_wr(21'h1ABCD, 16'h00A0);
    bus_wr(21'h00333, 16'h5555);
    finish_op();
    expect_start(3'd2, 21'h08000, 16'h0030, "R9 bypass block erase");
    bus_wr(21'h00000, 16'h0080);
    bus_wr(21'h08000, 16'h0030);
    finish_op();
    // R12 bad cycle keeps bypass
    bus_wr(21'h00000, 16'h0077);
    expect_start(3'd1, 21'h00444, 16'h0A0A, "R12 still bypass");
    bus_wr(21'h00000, 16'h00A0);
    bus_wr(21'h00444, 16'h0A0A);
    finish_op();
    expect_start(3'd3, 21'h00001, 16'h0010, "R9 bypass chip erase");
    bus_wr(21'h00000, 16'h0080);
    bus_wr(21'h00001, 16'h0010);
    finish_op();
    sb_drained("R9 drained");

    // R10 exit bypass
    bus_wr(21'h00000, 16'h0090);
    bus_wr(21'h00000, 16'h0000);
    bus_wr(21'h00000, 16'h00A0);
    bus_wr(21'h00555, 16'h6666);
    chk("R10 no start after exit", ready_o, 1);
    repeat (2) @(negedge clk);
    sb_drained("R10 drained");

    // R11 protected program window
    unlock();
    bus_wr(21'h555, 16'h00A0);
    lock_i = 1'b1;
    bus_wr(21'h00600, 16'h0000);
    lock_i = 1'b0;
    n = 0;
    while (!ready_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R11 program lock window", n, PPC);

    // R11 protected block erase window
    erase_prefix();
    lock_i = 1'b1;
    bus_wr(21'h0C000, 16'h0030);
    lock_i = 1'b0;
    n = 0;
    while (!ready_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R11 erase lock window", n, PEC);

    // R11 chip erase not affected by lock
    expect_start(3'd3, 21'h00555, 16'h0010, "R11 chip erase lock");
    erase_prefix();
    lock_i = 1'b1;
    bus_wr(21'h00555, 16'h0010);
    lock_i = 1'b0;
    finish_op();
    repeat (2) @(negedge clk);
    sb_drained("R11 drained");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule